// File: doc/BRIEF.md
# Receive Idle Timeout Timer

This block watches the receive side of a serial port and reports when the line has been quiet for too long. Each received byte starts a count that lasts a programmable whole number of character times. If the count runs out, the block sets a sticky timeout status flag and pulses a receive interrupt request. It does this only when unread data is waiting, or when a force control is set. Software clears the flag by writing a one to bit 3 of the status write port.

The character time is computed in clock ticks from the line settings and a baud divisor that has a fractional part. These timing settings are captured on a configuration write. A write whose divisor is zero is dropped, so the settings in use stay as they were. A count can be ended early in three ways: the enable is dropped, the receive buffer reaches its trigger level, or the multiplier is zero at restart, in which case the count never starts.

Top module: `rx_timeout_timer`

## Requirements
- R1: After reset the status flag and the interrupt request are 0. The timing in use is a bit period of 32 clocks and a frame of 10 bits.
- R2: The bit period in clocks is 16*divisor + fraction + 16, where the fraction is 3 bits. The frame length is (dsel+5) data bits, plus 2 stop bits when two_stop is 1 (else 1), plus 1 start bit. The count expires mult*frame*period clock edges after the edge that samples rx_byte.
- R3: The count advances only while tmo_en is 1. A cycle with tmo_en at 0 cancels any running count.
- R4: Every rx_byte restarts the count from its full length, using the multiplier and timing in use at that cycle.
- R5: rx_trig_hit cancels a running count. It also overrides an rx_byte in the same cycle.
- R6: At expiry, if rx_data_ready or tmo_force is 1, the status flag is set and rx_irq is high for exactly one cycle, both visible after the expiry edge. Otherwise nothing is flagged and the count stops.
- R7: A cycle with sts_wr at 1 and sts_wdata bit 3 at 1 clears the status flag. The other bits of sts_wdata have no effect. A new expiry in the same cycle wins over the clear.
- R8: A cfg_wr with cfg_div equal to 0 is ignored. Any other cfg_wr captures divisor, fraction, dsel and two_stop for counts started afterwards.
- R9: A multiplier of 0 at restart never produces an expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmo_en | input | 1 | Timeout counting enable |
| tmo_force | input | 1 | Flag expiry even without data ready |
| tmo_mult | input | MULT_W | Timeout length in character times |
| cfg_wr | input | 1 | Capture timing settings |
| cfg_div | input | DIV_W | Integer baud divisor |
| cfg_frac | input | FRAC_W | Fractional divisor add |
| cfg_dsel | input | 2 | Data bits minus 5 |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| rx_byte | input | 1 | A byte was received (restart) |
| rx_trig_hit | input | 1 | Receive trigger level reached (cancel) |
| rx_data_ready | input | 1 | Unread receive data present |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 8 | Status write data, bit 3 clears |
| rx_timeout_sts | output | 1 | Sticky timeout status |
| rx_irq | output | 1 | One-cycle receive interrupt request |

## Verification
The assertions assume that all control inputs are synchronous to clk and that rx_byte, rx_trig_hit, cfg_wr and sts_wr are single-cycle strobes. They also assume that no new expiry can follow an earlier one within one cycle. This holds because the shortest possible count is 7*32 clocks. The stimulus changes every input on the falling edge, and it pulses each strobe for exactly one cycle. It always writes a nonzero divisor before relying on new timing, except in the case that deliberately checks that a zero divisor is ignored.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
  localparam int FRAME_W       = 4;
  localparam int RST_PER_TICKS = 32;
  localparam int RST_FRAME     = 10;

  function automatic logic [FRAME_W-1:0] frame_len(input logic [1:0] dsel,
                                                   input logic two_stop);
    logic [FRAME_W-1:0] stop_n;
    stop_n = two_stop ? FRAME_W'(2) : FRAME_W'(1);
    return FRAME_W'(dsel) + FRAME_W'(6) + stop_n;
  endfunction
endpackage

// File: rtl/rxto_char_time.sv
module rxto_char_time
  import rxto_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 3,
  parameter int PER_W  = DIV_W + 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic [FRAC_W-1:0]  cfg_frac,
  input  logic [1:0]         cfg_dsel,
  input  logic               cfg_two_stop,
  output logic [PER_W-1:0]   per_ticks,
  output logic [FRAME_W-1:0] frame_bits
);
  logic [PER_W-1:0]   per_q, per_d;
  logic [FRAME_W-1:0] frm_q, frm_d;
  logic               take;

  assign take = cfg_wr && (cfg_div != '0);

  always_comb begin
    per_d = per_q;
    frm_d = frm_q;
    if (take) begin
      per_d = PER_W'({cfg_div, 4'b0000}) + PER_W'(cfg_frac) + PER_W'(16);
      frm_d = frame_len(cfg_dsel, cfg_two_stop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= PER_W'(RST_PER_TICKS);
      frm_q <= FRAME_W'(RST_FRAME);
    end else if (take) begin
      per_q <= per_d;
      frm_q <= frm_d;
    end
  end

  assign per_ticks  = per_q;
  assign frame_bits = frm_q;

  p_div0_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_div == '0) |=> ($stable(per_q) && $stable(frm_q)));

  p_per_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q >= PER_W'(32)) && (frm_q >= FRAME_W'(7)));
endmodule

// File: rtl/rxto_countdown.sv
module rxto_countdown
  import rxto_pkg::*;
#(
  parameter int PER_W  = 21,
  parameter int MULT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               restart,
  input  logic               cancel,
  input  logic [MULT_W-1:0]  mult,
  input  logic [PER_W-1:0]   per_ticks,
  input  logic [FRAME_W-1:0] frame_bits,
  output logic               expire
);
  logic               armed_q, armed_d;
  logic [PER_W-1:0]   per_q, per_d;
  logic [FRAME_W-1:0] bit_q, bit_d;
  logic [MULT_W-1:0]  chr_q, chr_d;
  logic               at_end, load, tick_ce;

  assign at_end  = (per_q == '0) && (bit_q == '0) && (chr_q == '0);
  assign load    = en && !cancel && restart;
  assign expire  = en && !cancel && !restart && armed_q && at_end;
  assign tick_ce = load || (en && !cancel && armed_q);

  always_comb begin
    armed_d = armed_q;
    per_d   = per_q;
    bit_d   = bit_q;
    chr_d   = chr_q;
    if (!en || cancel) begin
      armed_d = 1'b0;
    end else if (restart) begin
      armed_d = (mult != '0);
      per_d   = per_ticks - PER_W'(1);
      bit_d   = frame_bits - FRAME_W'(1);
      chr_d   = mult - MULT_W'(1);
    end else if (armed_q) begin
      if (at_end) begin
        armed_d = 1'b0;
      end else if (per_q != '0) begin
        per_d = per_q - PER_W'(1);
      end else begin
        per_d = per_ticks - PER_W'(1);
        if (bit_q != '0) begin
          bit_d = bit_q - FRAME_W'(1);
        end else begin
          bit_d = frame_bits - FRAME_W'(1);
          chr_d = chr_q - MULT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      per_q   <= '0;
      bit_q   <= '0;
      chr_q   <= '0;
    end else begin
      armed_q <= armed_d;
      if (tick_ce) begin
        per_q <= per_d;
        bit_q <= bit_d;
        chr_q <= chr_d;
      end
    end
  end

  p_disable_cancels_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !armed_q);

  p_trig_cancels_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cancel) |=> !armed_q);

  p_zero_mult_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && mult == '0) |=> !armed_q);

  p_restart_arms_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && mult != '0) |=> armed_q);
endmodule

// File: rtl/rx_timeout_timer.sv
module rx_timeout_timer
  import rxto_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 3,
  parameter int MULT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmo_en,
  input  logic              tmo_force,
  input  logic [MULT_W-1:0] tmo_mult,
  input  logic              cfg_wr,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [FRAC_W-1:0] cfg_frac,
  input  logic [1:0]        cfg_dsel,
  input  logic              cfg_two_stop,
  input  logic              rx_byte,
  input  logic              rx_trig_hit,
  input  logic              rx_data_ready,
  input  logic              sts_wr,
  input  logic [7:0]        sts_wdata,
  output logic              rx_timeout_sts,
  output logic              rx_irq
);
  localparam int PER_W   = DIV_W + 5;
  localparam int CLR_BIT = 3;

  logic [PER_W-1:0]   per_ticks;
  logic [FRAME_W-1:0] frame_bits;
  logic               expire, flag_set, flag_clr;
  logic               sts_q, sts_d, irq_q, irq_d;

  rxto_char_time #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .PER_W(PER_W)) u_ctime (
    .clk, .rst_n, .cfg_wr, .cfg_div, .cfg_frac, .cfg_dsel, .cfg_two_stop,
    .per_ticks, .frame_bits
  );

  rxto_countdown #(.PER_W(PER_W), .MULT_W(MULT_W)) u_cnt (
    .clk, .rst_n, .en(tmo_en), .restart(rx_byte), .cancel(rx_trig_hit),
    .mult(tmo_mult), .per_ticks, .frame_bits, .expire
  );

  assign flag_set = expire && (rx_data_ready || tmo_force);
  assign flag_clr = sts_wr && sts_wdata[CLR_BIT];

  always_comb begin
    sts_d = sts_q;
    if (flag_set)      sts_d = 1'b1;
    else if (flag_clr) sts_d = 1'b0;
    irq_d = flag_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      irq_q <= irq_d;
    end
  end

  assign rx_timeout_sts = sts_q;
  assign rx_irq         = irq_q;

  p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  p_irq_with_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> sts_q);

  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !flag_set) |=> !sts_q);

  p_no_data_no_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !rx_data_ready && !tmo_force && !sts_q) |=> !sts_q);
endmodule

// File: tb/rx_timeout_timer_tb_top.sv
module rx_timeout_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tmo_en, tmo_force, cfg_wr, cfg_two_stop;
  logic [3:0] tmo_mult;
  logic [15:0] cfg_div;
  logic [2:0] cfg_frac;
  logic [1:0] cfg_dsel;
  logic       rx_byte, rx_trig_hit, rx_data_ready, sts_wr;
  logic [7:0] sts_wdata;
  logic       rx_timeout_sts, rx_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  rx_timeout_timer dut_i (
    .clk, .rst_n, .tmo_en, .tmo_force, .tmo_mult, .cfg_wr, .cfg_div,
    .cfg_frac, .cfg_dsel, .cfg_two_stop, .rx_byte, .rx_trig_hit,
    .rx_data_ready, .sts_wr, .sts_wdata, .rx_timeout_sts, .rx_irq
  );

  // div, frac, dsel, two_stop, mult
  localparam int NV = 5;
  localparam int VEC [NV][5] = '{
    '{1, 0, 0, 0, 1},
    '{2, 5, 3, 1, 2},
    '{1, 7, 1, 0, 3},
    '{3, 2, 2, 1, 1},
    '{1, 3, 3, 0, 4}
  };

  function automatic int exp_ticks(int dv, int fr, int ds, int ts, int m);
    return m * (ds + 5 + (ts != 0 ? 2 : 1) + 1) * (16 * dv + fr + 16);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cfg(input int dv, input int fr, input int ds, input int ts);
    @(negedge clk);
    cfg_div = 16'(dv); cfg_frac = 3'(fr); cfg_dsel = 2'(ds); cfg_two_stop = ts[0];
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk);
    rx_byte = 1'b1;
    @(negedge clk);
    rx_byte = 1'b0;
  endtask

  task automatic strobe_trig();
    @(negedge clk);
    rx_trig_hit = 1'b1;
    @(negedge clk);
    rx_trig_hit = 1'b0;
  endtask

  task automatic wr_sts(input logic [7:0] d);
    @(negedge clk);
    sts_wr = 1'b1; sts_wdata = d;
    @(negedge clk);
    sts_wr = 1'b0; sts_wdata = '0;
  endtask

  // call right after kick(): counts edges after the sampling edge
  task automatic measure(output int n, output logic irq_at);
    n = 0; irq_at = 1'b0;
    while (n < 30000) begin
      @(posedge clk); n++; #1;
      if (rx_timeout_sts) begin irq_at = rx_irq; break; end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n; logic irq_at; int t;
    rst_n = 1'b0; tmo_en = 0; tmo_force = 0; tmo_mult = 0; cfg_wr = 0;
    cfg_div = 0; cfg_frac = 0; cfg_dsel = 0; cfg_two_stop = 0;
    rx_byte = 0; rx_trig_hit = 0; rx_data_ready = 0; sts_wr = 0; sts_wdata = 0;
    cyc(3);
    #1;
    chk(rx_timeout_sts == 0, "R1 sts in reset", rx_timeout_sts, 0);
    chk(rx_irq == 0, "R1 irq in reset", rx_irq, 0);
    @(negedge clk); rst_n = 1'b1;
    cyc(2);
    chk(rx_timeout_sts == 0 && rx_irq == 0, "R1 after reset", rx_timeout_sts, 0);

    // R1 reset timing: 10 bits x 32 clocks
    tmo_en = 1; tmo_mult = 1; rx_data_ready = 1;
    kick(); measure(n, irq_at);
    chk(n == 320, "R1 reset char time", n, 320);
    wr_sts(8'h08);

    // vector table: R2 length, R6 irq pulse, R7 clear
    for (int v = 0; v < NV; v++) begin
      cfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      tmo_mult = 4'(VEC[v][4]);
      t = exp_ticks(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
      kick(); measure(n, irq_at);
      chk(n == t, "R2 timeout length", n, t);
      chk(irq_at == 1, "R6 irq with flag", irq_at, 1);
      @(posedge clk); #1;
      chk(rx_irq == 0, "R6 irq one cycle", rx_irq, 0);
      chk(rx_timeout_sts == 1, "R6 flag sticky", rx_timeout_sts, 1);
      if (v == 0) begin
        wr_sts(8'hF7); #1;
        chk(rx_timeout_sts == 1, "R7 other bits no clear", rx_timeout_sts, 1);
      end
      wr_sts(8'h08); #1;
      chk(rx_timeout_sts == 0, "R7 write-1 clears", rx_timeout_sts, 0);
    end

    // directed timing base: div1 frac0 dsel0 one stop -> 224 per char
    cfg(1, 0, 0, 0); tmo_mult = 1; t = 224;

    // R8: zero divisor ignored
    cfg(0, 7, 3, 1);
    kick(); measure(n, irq_at);
    chk(n == t, "R8 zero divisor ignored", n, t);
    wr_sts(8'h08);

    // R6: no data, no force -> nothing, count ends
    rx_data_ready = 0; tmo_force = 0;
    kick(); cyc(t + 20); #1;
    chk(rx_timeout_sts == 0, "R6 no data no flag", rx_timeout_sts, 0);
    rx_data_ready = 1; cyc(t + 20); #1;
    chk(rx_timeout_sts == 0, "R6 count ended", rx_timeout_sts, 0);
    // R6: force with no data
    rx_data_ready = 0; tmo_force = 1;
    kick(); measure(n, irq_at);
    chk(n == t, "R6 force fires", n, t);
    tmo_force = 0; rx_data_ready = 1;
    wr_sts(8'h08);

    // R9: zero multiplier
    tmo_mult = 0;
    kick(); cyc(2000); #1;
    chk(rx_timeout_sts == 0, "R9 zero mult never fires", rx_timeout_sts, 0);
    tmo_mult = 1;

    // R3: disable mid-count cancels
    kick(); cyc(100);
    tmo_en = 0; cyc(1); tmo_en = 1;
    cyc(t + 20); #1;
    chk(rx_timeout_sts == 0, "R3 disable cancels", rx_timeout_sts, 0);

    // R5: trigger cancels, and overrides a same-cycle byte
    kick(); cyc(100); strobe_trig();
    cyc(t + 20); #1;
    chk(rx_timeout_sts == 0, "R5 trigger cancels", rx_timeout_sts, 0);
    @(negedge clk); rx_byte = 1; rx_trig_hit = 1;
    @(negedge clk); rx_byte = 0; rx_trig_hit = 0;
    cyc(t + 20); #1;
    chk(rx_timeout_sts == 0, "R5 trigger beats byte", rx_timeout_sts, 0);

    // R4: byte restarts full length
    kick(); cyc(150);
    kick(); measure(n, irq_at);
    chk(n == t, "R4 restart full length", n, t);
    wr_sts(8'h08);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule